// File: doc/BRIEF.md
# Operate Microinstruction Phase Sequencer

This block carries out one operate-class microinstruction on a W-bit accumulator and a one-bit link register, with a W-bit data-switch word as an extra operand. The low six bits of the instruction each turn on one micro-operation. The micro-operations are sorted into three phases that run one clock apart. The first phase clears. The second complements. The third increments and then merges the switch word. Because of this fixed order, any mix of the six bits gives one well-defined result. For example, clear together with complement leaves the accumulator all ones.

A caller pulses `start` for one cycle while the sequencer is idle and presents the instruction bits on `op` at the same time. The accumulator and link are registered outputs. They keep their values between instructions, so one instruction can work on the result of the previous one. The `done` output pulses for one cycle once the third phase has been applied. While an instruction is in progress, any new `start` is ignored.

Top module: `opr_seq`

## Requirements
- R1: After reset, `ac` is 0, `lnk` is 0 and `done` is 0.
- R2: In phase one, `op[0]` sets the accumulator to zero and `op[3]` sets the link to zero.
- R3: In phase two, `op[1]` replaces the accumulator with its bitwise complement and `op[4]` inverts the link.
- R4: In phase three, `op[2]` adds one to the accumulator modulo 2^W. When the addition carries out of bit W-1, the link is inverted.
- R5: In phase three, `op[5]` ORs `ds` into the accumulator. This happens after any increment, and `ds` is sampled in the phase-three cycle.
- R6: Each phase works on the results of the phase before it. For example, `op`=octal 003 leaves the accumulator all ones whatever its previous value was.
- R7: If `start` is sampled high at a clock edge, the three phases are applied at the next three edges. `done` is then high for exactly the one cycle that follows the third of those edges.
- R8: An instruction with all six `op` bits zero completes with `ac` and `lnk` unchanged.
- R9: A `start` that arrives while an instruction is in progress is ignored. It neither changes the result of the current instruction nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (accepted only when idle) |
| op | input | 6 | Micro-operation enables, bit 0..5 |
| ds | input | W | Data-switch word merged by op[5] |
| ac | output | W | Accumulator |
| lnk | output | 1 | Link bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is one where the result depends on the starting accumulator and link values combined with every order-sensitive mix of bits. The main examples are an increment that carries out of an all-ones word and a link that is cleared and then inverted. There is no load port, so the bench first puts the block into each starting state with ordinary instructions: octal 051 loads `ds` into the accumulator and clears the link, and octal 020 then sets the link when needed. Only after that does it run each of the 64 bit combinations and compare the result with an arithmetic model. A second start pulse in the middle of an instruction is injected separately to show that it is ignored.

// File: rtl/opr_seq.sv
module opr_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   op,
  input  logic [W-1:0] ds,
  output logic [W-1:0] ac,
  output logic         lnk,
  output logic         done
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_DONE} st_t;

  st_t          st;
  logic [5:0]   op_q;
  logic [W:0]   inc_sum;
  logic [W-1:0] after_inc;
  logic [W-1:0] t3_ac;

  assign inc_sum   = {1'b0, ac} + {{W{1'b0}}, 1'b1};
  assign after_inc = op_q[2] ? inc_sum[W-1:0] : ac;
  assign t3_ac     = after_inc | (op_q[5] ? ds : '0);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      op_q <= '0;
      ac   <= '0;
      lnk  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q <= op;
          st   <= S_T1;
        end
        S_T1: begin
          if (op_q[0]) ac  <= '0;
          if (op_q[3]) lnk <= 1'b0;
          st <= S_T2;
        end
        S_T2: begin
          if (op_q[1]) ac  <= ~ac;
          if (op_q[4]) lnk <= ~lnk;
          st <= S_T3;
        end
        S_T3: begin
          ac  <= t3_ac;
          lnk <= lnk ^ (op_q[2] & inc_sum[W]);
          st  <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_T1_CLEAR_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1 && op_q[0]) |=> (ac == '0)); // R2
  AST_T1_CLEAR_L: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1 && op_q[3]) |=> !lnk); // R2
  AST_T2_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 && op_q[1]) |=> (ac == ~$past(ac))); // R3
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3 && op_q[2] && !op_q[5] && (&ac)) |=> (ac == '0 && lnk != $past(lnk))); // R4
  AST_OR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3 && op_q[5]) |=> ((ac & $past(ds)) == $past(ds))); // R5
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3) |=> done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_DONE) |=> ($stable(ac) && $stable(lnk))); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(op_q)); // R9

endmodule

// File: tb/opr_seq_tb.sv
module opr_seq_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   op = '0;
  logic [W-1:0] ds = '0;
  logic [W-1:0] ac;
  logic         lnk;
  logic         done;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opr_seq #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ds(ds),
    .ac(ac), .lnk(lnk), .done(done)
  );

  function automatic logic [W:0] model(input logic [5:0] o, input logic [W-1:0] a,
                                       input logic l, input logic [W-1:0] d);
    logic [W:0] s;
    if (o[0]) a = '0;
    if (o[3]) l = 1'b0;
    if (o[1]) a = ~a;
    if (o[4]) l = ~l;
    if (o[2]) begin
      s = {1'b0, a} + 1;
      a = s[W-1:0];
      if (s[W]) l = ~l;
    end
    if (o[5]) a = a | d;
    return {l, a};
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input logic [5:0] o, input logic [W-1:0] d, input bit chk_done);
    @(negedge clk);
    start = 1'b1; op = o; ds = d;
    @(negedge clk);
    start = 1'b0; op = '0;
    repeat (3) @(negedge clk);
    if (chk_done) check("R7 done high", {{W{1'b0}}, done}, {{W{1'b0}}, 1'b1});
    @(negedge clk);
    if (chk_done) check("R7 done pulse", {{W{1'b0}}, done}, '0);
  endtask

  task automatic preload(input logic [W-1:0] a, input logic l);
    run(6'o51, a, 0);
    if (l) run(6'o20, '0, 0);
  endtask

  initial begin
    logic [W-1:0] pa [6] = '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h1234, 16'h7FFF, 16'h5A5A};
    logic         pl [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    logic [W-1:0] pd [6] = '{16'h0000, 16'h0000, 16'h00F0, 16'h8001, 16'hFFFF, 16'h0F0F};
    logic [W:0] exp;
    repeat (3) @(negedge clk);
    check("R1 reset", {lnk, ac}, '0);
    check("R1 reset done", {{W{1'b0}}, done}, '0);
    rst_n = 1'b1;

    preload(16'h0F0F, 1'b1);
    run(6'o03, 16'h0000, 1);
    check("R6 clear+cpl gives ones", {lnk, ac}, {1'b1, 16'hFFFF});

    preload(16'hABCD, 1'b1);
    run(6'o00, 16'hFFFF, 1);
    check("R8 no-op unchanged", {lnk, ac}, {1'b1, 16'hABCD});

    preload(16'hFFFF, 1'b0);
    run(6'o04, 16'h0000, 1);
    check("R4 increment carry", {lnk, ac}, {1'b1, 16'h0000});

    preload(16'hFFFF, 1'b0);
    run(6'o44, 16'h0003, 1);
    check("R5 OR after increment", {lnk, ac}, {1'b1, 16'h0003});

    preload(16'h0010, 1'b0);
    @(negedge clk);
    start = 1'b1; op = 6'o04; ds = '0;
    @(negedge clk);
    op = 6'o03;
    @(negedge clk);
    start = 1'b0; op = '0;
    repeat (2) @(negedge clk);
    check("R9 busy start done", {{W{1'b0}}, done}, {{W{1'b0}}, 1'b1});
    check("R9 busy start ignored", {lnk, ac}, {1'b0, 16'h0011});
    repeat (3) @(negedge clk);
    check("R9 no second run", {lnk, ac}, {1'b0, 16'h0011});

    for (int p = 0; p < 6; p++) begin
      for (int o = 0; o < 64; o++) begin
        preload(pa[p], pl[p]);
        run(o[5:0], pd[p], (o % 16) == 0);
        exp = model(o[5:0], pa[p], pl[p], pd[p]);
        check($sformatf("R2 R3 R4 R5 R6 op=%0o", o), {lnk, ac}, exp);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule